// File: doc/BRIEF.md
# Dual 40-bit Multiply-Accumulate Unit

This block multiplies two 16-bit operands and combines the product with one of two 40-bit accumulators held inside it. Each request either loads the product into the chosen accumulator, adds the product to it, or subtracts the product from it. The operands can be taken as signed by signed, signed by unsigned, or unsigned by unsigned.

Two mode inputs change the arithmetic. Fractional mode doubles the product before it is used. Saturation mode clamps results to the 32-bit signed range, and it affects only the signed-by-signed forms. In those forms the product is limited first, and the final value is then limited again and stored sign-extended in 40 bits. Every other result wraps modulo 2^40.

A request is accepted on a rising clock edge while `en` is high, and it updates the accumulator in that same edge. `acc_out` always shows the accumulator named by `acc_sel`. A caller can therefore read either accumulator by setting `acc_sel` with `en` low.

Top module: `mac40`

## Requirements
- R1: After reset both accumulators hold zero.
- R2: A multiply-only request (op_kind=0) writes the product of the two operands into the selected accumulator. The product is doubled in fractional mode and reduced modulo 2^40. The operand form decides signedness: op_form=0 treats both operands as signed, op_form=1 treats opnd_a as signed and opnd_b as unsigned, and op_form=2 or 3 treats both as unsigned.
- R3: With frac_mode=1, the product is shifted left by one bit before it is clamped, added or subtracted.
- R4: For the signed-by-signed form (op_form=0) with sat_mode=1, a product above 2^31-1 is replaced by 2^31-1 before it is used. The final result is then clamped to the range -2^31 to 2^31-1 and stored sign-extended to 40 bits.
- R5: A multiply-add request (op_kind=1) writes accumulator plus product. Without saturation the sum wraps modulo 2^40, with the accumulator read as a 40-bit two's-complement value.
- R6: For op_form 1, 2 and 3, sat_mode has no effect, and results always wrap modulo 2^40.
- R7: A multiply-subtract request (op_kind=2) writes accumulator minus product, under the same clamping and wrapping rules as multiply-add.
- R8: Only the accumulator chosen by acc_sel (0 or 1) changes. With en low, neither accumulator changes.
- R9: op_kind=3 leaves both accumulators unchanged, even with en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Accept a request on this edge |
| op_kind | input | 2 | 0 multiply-only, 1 multiply-add, 2 multiply-subtract, 3 hold |
| op_form | input | 2 | 0 signed×signed, 1 signed×unsigned, 2/3 unsigned×unsigned |
| frac_mode | input | 1 | Double the product |
| sat_mode | input | 1 | Clamp signed×signed results to the 32-bit signed range |
| acc_sel | input | 1 | Accumulator to update and to show |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| acc_out | output | 40 | Current value of the selected accumulator |

## Verification
The assertions check on every cycle that a saturating signed-by-signed write leaves a value that is sign-extended from 32 bits. They also check that the unselected accumulator and idle or hold cycles leave state untouched. Only the bench scenarios can show the arithmetic itself. This covers the exact product under each signedness form, the doubling, the product clamp applied before the add, 40-bit wrap-around on long accumulation runs, and the fact that saturation has no effect on the mixed and unsigned forms. The bench compares every accumulator against an arithmetic model over a sweep of corner operands and all mode combinations.

// File: rtl/mac40.sv
module mac40 #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int SATW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      op_kind,
  input  logic [1:0]      op_form,
  input  logic            frac_mode,
  input  logic            sat_mode,
  input  logic            acc_sel,
  input  logic [OPW-1:0]  opnd_a,
  input  logic [OPW-1:0]  opnd_b,
  output logic [ACCW-1:0] acc_out
);
  localparam int PW = 2*OPW + 3;
  localparam int VW = ACCW + 2;
  localparam logic signed [VW-1:0] SMAX = {{(VW-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
  localparam logic signed [VW-1:0] SMIN = {{(VW-SATW+1){1'b1}}, {(SATW-1){1'b0}}};

  logic [ACCW-1:0] acc0, acc1, cur, res;
  logic signed [OPW:0]     ea, eb;
  logic signed [2*OPW+1:0] prod;
  logic signed [PW-1:0]    prod_f;
  logic signed [VW-1:0]    pv, pc, av, v, vc;
  logic ss, clamp_on, wr;

  assign ss       = (op_form == 2'd0);
  assign clamp_on = ss && sat_mode;
  assign wr       = en && (op_kind != 2'd3);

  assign ea = {(op_form != 2'd2 && op_form != 2'd3) & opnd_a[OPW-1], opnd_a};
  assign eb = {ss & opnd_b[OPW-1], opnd_b};
  assign prod   = ea * eb;
  assign prod_f = frac_mode ? {prod, 1'b0} : {prod[2*OPW+1], prod};
  assign pv     = {{(VW-PW){prod_f[PW-1]}}, prod_f};
  assign pc     = (clamp_on && pv > SMAX) ? SMAX : pv;

  assign cur = acc_sel ? acc1 : acc0;
  assign av  = {{(VW-ACCW){cur[ACCW-1]}}, cur};

  always_comb begin
    case (op_kind)
      2'd0:    v = pc;
      2'd1:    v = av + pc;
      2'd2:    v = av - pc;
      default: v = av;
    endcase
  end

  assign vc  = !clamp_on ? v : (v > SMAX) ? SMAX : (v < SMIN) ? SMIN : v;
  assign res = vc[ACCW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0 <= '0;
      acc1 <= '0;
    end else if (wr) begin
      if (acc_sel) acc1 <= res;
      else         acc0 <= res;
    end
  end

  assign acc_out = acc_sel ? acc1 : acc0;

  logic ok0, ok1;
  assign ok0 = (&acc0[ACCW-1:SATW-1]) || (~|acc0[ACCW-1:SATW-1]);
  assign ok1 = (&acc1[ACCW-1:SATW-1]) || (~|acc1[ACCW-1:SATW-1]);

  p_sat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_kind != 2'd3 && op_form == 2'd0 && sat_mode) |=> ($past(acc_sel) ? ok1 : ok0));

  p_acc1_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !acc_sel) |=> $stable(acc1));

  p_acc0_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_sel) |=> $stable(acc0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || op_kind == 2'd3) |=> ($stable(acc0) && $stable(acc1)));
endmodule

// File: tb/tb_mac40.sv
module tb_mac40;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, frac_mode = 1'b0, sat_mode = 1'b0, acc_sel = 1'b0;
  logic [1:0] op_kind = 2'd0, op_form = 2'd0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [39:0] acc_out;
  logic [39:0] model [2];
  int checks = 0, errors = 0;
  bit done = 0;

  mac40 dut (.clk, .rst_n, .en, .op_kind, .op_form, .frac_mode, .sat_mode,
             .acc_sel, .opnd_a, .opnd_b, .acc_out);

  always #10 clk = ~clk;

  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;
  localparam longint M40   = 64'sd1 <<< 40;

  function automatic logic [39:0] ref_op(logic [39:0] acc, logic [1:0] k, logic [1:0] f,
                                         logic fr, logic st, logic [15:0] a, logic [15:0] b);
    longint pa, pb, p, ac, r;
    logic ssat;
    if (k == 2'd3) return acc;
    pa = (f == 2'd0 || f == 2'd1) ? longint'($signed(a)) : longint'(a);
    pb = (f == 2'd0) ? longint'($signed(b)) : longint'(b);
    p = pa * pb;
    if (fr) p = p * 2;
    ssat = (f == 2'd0) && st;
    if (ssat && p > MAX32) p = MAX32;
    ac = longint'(acc);
    if (acc[39]) ac = ac - M40;
    r = (k == 2'd0) ? p : (k == 2'd1) ? ac + p : ac - p;
    if (ssat) begin
      if (r > MAX32) r = MAX32;
      else if (r < MIN32) r = MIN32;
    end
    return r[39:0];
  endfunction

  task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] k, logic [1:0] f, logic fr, logic st);
    if (k == 2'd3) return "R9";
    if (f == 2'd0 && st) return "R4";
    if (f != 2'd0 && st) return "R6";
    if (k == 2'd2) return "R7";
    if (fr) return "R3";
    if (k == 2'd0) return "R2";
    return "R5";
  endfunction

  task automatic do_op(logic [1:0] k, logic [1:0] f, logic fr, logic st, logic s,
                       logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    en = 1'b1; op_kind = k; op_form = f; frac_mode = fr; sat_mode = st;
    acc_sel = s; opnd_a = a; opnd_b = b;
    model[s] = ref_op(model[s], k, f, fr, st, a, b);
    @(negedge clk);
    en = 1'b0;
    #1 check(tag_of(k, f, fr, st), acc_out, model[s]);
    acc_sel = ~s;
    #1 check("R8 other", acc_out, model[~s]);
  endtask

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h8001, 16'h1234, 16'hC3A5};
    model[0] = '0; model[1] = '0;
    #35 rst_n = 1'b1;
    @(negedge clk);
    acc_sel = 1'b0; #1 check("R1", acc_out, 40'h0);
    acc_sel = 1'b1; #1 check("R1", acc_out, 40'h0);

    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 4; f++)
        for (int m = 0; m < 4; m++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
              do_op(k[1:0], f[1:0], m[0], m[1], 1'(i ^ j), vals[i], vals[j]);

    do_op(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    for (int n = 0; n < 6; n++)
      do_op(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF);
    for (int n = 0; n < 6; n++)
      do_op(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
    do_op(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);

    do_op(2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000);
    for (int n = 0; n < 200; n++)
      do_op(2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF);
    for (int n = 0; n < 200; n++)
      do_op(2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 16'h8000, 16'hFFFF);

    @(negedge clk);
    en = 1'b0; op_kind = 2'd1; op_form = 2'd0; acc_sel = 1'b0;
    opnd_a = 16'h4000; opnd_b = 16'h4000;
    @(negedge clk);
    #1 check("R8 en low", acc_out, model[0]);
    acc_sel = 1'b1;
    #1 check("R8 en low", acc_out, model[1]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule